// File: doc/BRIEF.md
# Affinity-Partitioned Snoop Filter Directory

This block is a line directory held in the memory controller. It keeps a tag and a two-bit coherency state for every line that either of two processor caches may hold. It never stores line data. Each processor port can ask for a lookup, an add/update or an invalidate of one line address. The directory answers with hit or miss, the affinity group that holds the line, the stored state, and a forward flag. The forward flag tells the coherence logic whether the other processor's bus has to be snooped. Snoops that do not need the remote bus are filtered out.

The tag store is split into two affinity groups, one per processor. Each group has its own valid bits, tags, states and tree pseudo-LRU bits for every set. A hit check compares the tag against every way of both groups in the indexed set. A new line is only ever placed in the requester's own group. When that group's set is full, a victim is evicted from it, and the evicted line's address is reported with a one-cycle pulse so that a back-invalidate can be issued.

The block serves one request per cycle. When both ports request in the same cycle, processor 0 is served first and processor 1 is held back one cycle. The response carries the stall count each request paid.

Top module: `snoop_filter_dir`

## Requirements
- R1: A line address is split into a 6-bit byte offset (ignored), then log2(SETS) set-index bits, and the remaining upper bits as the tag. Addresses that differ only in the offset name the same line. The same tag in another set is a different line.
- R2: Op codes are 0 = lookup, 1 = add/update, 2 = invalidate, and 3 = lookup. A hit check searches all ways of both groups. On a hit, the response gives rsp_hit=1, rsp_grp set to the holding group, and rsp_state set to the state stored before the request.
- R3: rsp_fwd is 1 only when the line hits in the group of the other processor. A miss, or a hit in the requester's own group, gives rsp_fwd=0.
- R4: A lookup or add that misses places the line in the requester's group (group 0 for port 0, group 1 for port 1) with the request's state. The miss response has rsp_hit=0, rsp_grp equal to the requester, and rsp_state=0.
- R5: An allocation fills an invalid way of the requester's group before evicting anything. A full set in one group never causes an eviction when the other group allocates in that set.
- R6: Replacement uses 15-bit tree pseudo-LRU per set and group. Hits and allocations point the tree away from the way used. A miss into a full set raises evict_valid together with its response and gives the victim's address (offset bits zero) and its group. After that the victim line misses.
- R7: A request on port 0 with nothing held back is answered in the next cycle with rsp_stall=1. Port 0 wins when both ports request in the same cycle.
- R8: The losing or held-back request is answered one cycle after the winner with rsp_stall=2. A held-back request is served before a new request arrives in the same cycle, and that new request is then held back itself.
- R9: An add that hits rewrites the state of the existing entry in its current group and does not allocate, whichever port issues it.
- R10: An invalidate that hits removes the entry, so the next access to that line misses. An invalidate that misses allocates nothing.
- R11: After reset every entry is invalid and rsp_valid and evict_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p0_req | input | 1 | Port 0 request strobe |
| p0_op | input | 2 | Port 0 op code |
| p0_addr | input | ADDR_W | Port 0 line address |
| p0_state | input | 2 | Port 0 state to store |
| p1_req | input | 1 | Port 1 request strobe |
| p1_op | input | 2 | Port 1 op code |
| p1_addr | input | ADDR_W | Port 1 line address |
| p1_state | input | 2 | Port 1 state to store |
| rsp_valid | output | 1 | Response strobe |
| rsp_port | output | 1 | Port being answered |
| rsp_hit | output | 1 | Line found in either group |
| rsp_grp | output | 1 | Holding group, or requester on a miss |
| rsp_state | output | 2 | State before the request, 0 on a miss |
| rsp_fwd | output | 1 | Remote bus must be snooped |
| rsp_stall | output | 2 | Cycles from request to response |
| evict_valid | output | 1 | A valid victim was evicted |
| evict_grp | output | 1 | Group of the victim |
| evict_addr | output | ADDR_W | Line address of the victim |

## Verification
A stale or lost valid bit shows up at the first later access to that line. The response then reports a hit where a miss was due, or the reverse, and rsp_fwd follows the same error. A corrupted replacement tree stays hidden until a set fills up. It then shows as the wrong evict_addr in the cycle of the response to the miss that evicts. An error in the hold-back slot shows within two cycles of a collision, as a missing response, a swapped rsp_port or a wrong rsp_stall.

// File: rtl/sf_pkg.sv
`timescale 1ns/1ps
package sf_pkg;
   typedef enum logic [1:0] {
      OP_LOOKUP = 2'd0,
      OP_ADD    = 2'd1,
      OP_INVAL  = 2'd2,
      OP_LOOK2  = 2'd3
   } sf_op_e;

   localparam logic [1:0] ST_NONE = 2'd0;
endpackage

// File: rtl/sf_plru.sv
`timescale 1ns/1ps
module sf_plru #(
   parameter  int SETS  = 8,
   parameter  int WAYS  = 16,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS),
   localparam int NODES = WAYS - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] set_idx,
   output logic [WAY_W-1:0] victim,
   input  logic             touch_en,
   input  logic [WAY_W-1:0] touch_way
);
   logic [NODES-1:0] tree_q [SETS];
   logic [NODES-1:0] cur;
   logic [NODES-1:0] nxt;

   assign cur = tree_q[set_idx];

   // bit 0 at a node: victim lies in the lower-numbered half
   always_comb begin : walk
      logic [WAY_W-1:0] node;
      node   = '0;
      victim = '0;
      for (int l = 0; l < WAY_W; l++) begin
         victim[WAY_W-1-l] = cur[node];
         node = WAY_W'(2 * node + 1 + cur[node]);
      end
   end

   always_comb begin : away
      logic [WAY_W-1:0] node;
      logic             b;
      node = '0;
      nxt  = cur;
      for (int l = 0; l < WAY_W; l++) begin
         b         = touch_way[WAY_W-1-l];
         nxt[node] = ~b;
         node      = WAY_W'(2 * node + 1 + b);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
      end else if (touch_en) begin
         tree_q[set_idx] <= nxt;
      end
   end
endmodule

// File: rtl/sf_group.sv
`timescale 1ns/1ps
module sf_group #(
   parameter  int SETS  = 8,
   parameter  int WAYS  = 16,
   parameter  int TAG_W = 23,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] set_idx,
   input  logic [TAG_W-1:0] tag,
   output logic             hit,
   output logic [WAY_W-1:0] hit_way,
   output logic [1:0]       hit_st,
   output logic             full,
   output logic [WAY_W-1:0] vic_way,
   output logic [TAG_W-1:0] vic_tag,
   input  logic             wr_en,
   input  logic             clr_en,
   input  logic             touch_en,
   input  logic [WAY_W-1:0] acc_way,
   input  logic [1:0]       wr_st
);
   logic [WAYS-1:0]  vld_q [SETS];
   logic [TAG_W-1:0] tag_q [SETS][WAYS];
   logic [1:0]       st_q  [SETS][WAYS];
   logic [WAYS-1:0]  match;
   logic [WAY_W-1:0] free_way;
   logic [WAY_W-1:0] plru_way;

   always_comb begin
      for (int w = 0; w < WAYS; w++)
         match[w] = vld_q[set_idx][w] && (tag_q[set_idx][w] == tag);
      hit_way  = '0;
      free_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (match[w])           hit_way  = WAY_W'(w);
         if (!vld_q[set_idx][w]) free_way = WAY_W'(w);
      end
   end

   assign hit     = |match;
   assign hit_st  = st_q[set_idx][hit_way];
   assign full    = &vld_q[set_idx];
   assign vic_way = full ? plru_way : free_way;
   assign vic_tag = tag_q[set_idx][vic_way];

   sf_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_idx   (set_idx),
      .victim    (plru_way),
      .touch_en  (touch_en),
      .touch_way (acc_way)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      end else begin
         if (wr_en)  vld_q[set_idx][acc_way] <= 1'b1;
         if (clr_en) vld_q[set_idx][acc_way] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[set_idx][acc_way] <= tag;
         st_q[set_idx][acc_way]  <= wr_st;
      end
   end
endmodule

// File: rtl/sf_arb.sv
`timescale 1ns/1ps
module sf_arb #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              p0_req,
   input  logic [1:0]        p0_op,
   input  logic [ADDR_W-1:0] p0_addr,
   input  logic [1:0]        p0_state,
   input  logic              p1_req,
   input  logic [1:0]        p1_op,
   input  logic [ADDR_W-1:0] p1_addr,
   input  logic [1:0]        p1_state,
   output logic              srv_vld,
   output logic              srv_port,
   output logic [1:0]        srv_op,
   output logic [ADDR_W-1:0] srv_addr,
   output logic [1:0]        srv_st,
   output logic [1:0]        srv_stall,
   output logic              pend_vld
);
   logic              hold_q;
   logic              hold_port_q;
   logic [1:0]        hold_op_q;
   logic [ADDR_W-1:0] hold_addr_q;
   logic [1:0]        hold_st_q;
   logic              cap;
   logic              cap_port;

   assign pend_vld = hold_q;

   always_comb begin
      srv_vld   = 1'b0;
      srv_port  = 1'b0;
      srv_op    = p0_op;
      srv_addr  = p0_addr;
      srv_st    = p0_state;
      srv_stall = 2'd1;
      if (hold_q) begin
         srv_vld   = 1'b1;
         srv_port  = hold_port_q;
         srv_op    = hold_op_q;
         srv_addr  = hold_addr_q;
         srv_st    = hold_st_q;
         srv_stall = 2'd2;
      end else if (p0_req) begin
         srv_vld   = 1'b1;
      end else if (p1_req) begin
         srv_vld   = 1'b1;
         srv_port  = 1'b1;
         srv_op    = p1_op;
         srv_addr  = p1_addr;
         srv_st    = p1_state;
      end
   end

   // held request goes first, so any new arrival waits one cycle
   assign cap      = hold_q ? (p0_req | p1_req) : (p0_req & p1_req);
   assign cap_port = hold_q ? ~p0_req : 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) hold_q <= 1'b0;
      else        hold_q <= cap;
   end

   always_ff @(posedge clk) begin
      if (cap) begin
         hold_port_q <= cap_port;
         hold_op_q   <= cap_port ? p1_op    : p0_op;
         hold_addr_q <= cap_port ? p1_addr  : p0_addr;
         hold_st_q   <= cap_port ? p1_state : p0_state;
      end
   end
endmodule

// File: rtl/snoop_filter_dir.sv
`timescale 1ns/1ps
module snoop_filter_dir #(
   parameter  int ADDR_W     = 32,
   parameter  int SETS       = 8,
   parameter  int GRP_WAYS   = 16,
   parameter  int LINE_BYTES = 64,
   localparam int OFF_W      = $clog2(LINE_BYTES),
   localparam int SET_W      = $clog2(SETS),
   localparam int WAY_W      = $clog2(GRP_WAYS),
   localparam int TAG_W      = ADDR_W - OFF_W - SET_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              p0_req,
   input  logic [1:0]        p0_op,
   input  logic [ADDR_W-1:0] p0_addr,
   input  logic [1:0]        p0_state,
   input  logic              p1_req,
   input  logic [1:0]        p1_op,
   input  logic [ADDR_W-1:0] p1_addr,
   input  logic [1:0]        p1_state,
   output logic              rsp_valid,
   output logic              rsp_port,
   output logic              rsp_hit,
   output logic              rsp_grp,
   output logic [1:0]        rsp_state,
   output logic              rsp_fwd,
   output logic [1:0]        rsp_stall,
   output logic              evict_valid,
   output logic              evict_grp,
   output logic [ADDR_W-1:0] evict_addr
);
   import sf_pkg::*;

   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (GRP_WAYS < 2 || (GRP_WAYS & (GRP_WAYS - 1)) != 0) begin : g_bad_ways
      $error("GRP_WAYS must be a power of two of at least 2");
   end
   if (LINE_BYTES < 2 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("LINE_BYTES must be a power of two");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("address too narrow for the set and offset fields");
   end

   logic              srv_vld;
   logic              srv_port;
   logic [1:0]        srv_op;
   logic [ADDR_W-1:0] srv_addr;
   logic [1:0]        srv_st;
   logic [1:0]        srv_stall;
   logic              arb_pend;

   sf_arb #(.ADDR_W(ADDR_W)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .p0_req    (p0_req),
      .p0_op     (p0_op),
      .p0_addr   (p0_addr),
      .p0_state  (p0_state),
      .p1_req    (p1_req),
      .p1_op     (p1_op),
      .p1_addr   (p1_addr),
      .p1_state  (p1_state),
      .srv_vld   (srv_vld),
      .srv_port  (srv_port),
      .srv_op    (srv_op),
      .srv_addr  (srv_addr),
      .srv_st    (srv_st),
      .srv_stall (srv_stall),
      .pend_vld  (arb_pend)
   );

   logic [SET_W-1:0] set_idx;
   logic [TAG_W-1:0] tag;
   logic             unused_off;

   assign set_idx    = srv_addr[OFF_W +: SET_W];
   assign tag        = srv_addr[ADDR_W-1 -: TAG_W];
   assign unused_off = ^srv_addr[OFF_W-1:0];

   logic [1:0]       g_hit, g_full, g_wr, g_clr, g_touch;
   logic [WAY_W-1:0] g_hway [2];
   logic [WAY_W-1:0] g_vway [2];
   logic [WAY_W-1:0] g_acc  [2];
   logic [1:0]       g_hst  [2];
   logic [TAG_W-1:0] g_vtag [2];

   for (genvar g = 0; g < 2; g++) begin : g_aff
      sf_group #(.SETS(SETS), .WAYS(GRP_WAYS), .TAG_W(TAG_W)) u_grp (
         .clk      (clk),
         .rst_n    (rst_n),
         .set_idx  (set_idx),
         .tag      (tag),
         .hit      (g_hit[g]),
         .hit_way  (g_hway[g]),
         .hit_st   (g_hst[g]),
         .full     (g_full[g]),
         .vic_way  (g_vway[g]),
         .vic_tag  (g_vtag[g]),
         .wr_en    (g_wr[g]),
         .clr_en   (g_clr[g]),
         .touch_en (g_touch[g]),
         .acc_way  (g_acc[g]),
         .wr_st    (srv_st)
      );
   end

   logic       any_hit, hgrp, is_inv, is_add, alloc, do_evict;
   logic [1:0] hst;

   assign any_hit  = |g_hit;
   assign hgrp     = g_hit[1];
   assign hst      = g_hst[hgrp];
   assign is_inv   = srv_op == OP_INVAL;
   assign is_add   = srv_op == OP_ADD;
   assign alloc    = srv_vld && !any_hit && !is_inv;
   assign do_evict = alloc && g_full[srv_port];

   always_comb begin
      for (int g = 0; g < 2; g++) begin
         g_acc[g]   = g_hit[g] ? g_hway[g] : g_vway[g];
         g_wr[g]    = (alloc && srv_port == 1'(g)) ||
                      (srv_vld && g_hit[g] && is_add);
         g_clr[g]   = srv_vld && g_hit[g] && is_inv;
         g_touch[g] = g_wr[g] || (srv_vld && g_hit[g] && !is_inv);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_port    <= 1'b0;
         rsp_hit     <= 1'b0;
         rsp_grp     <= 1'b0;
         rsp_state   <= ST_NONE;
         rsp_fwd     <= 1'b0;
         rsp_stall   <= 2'd0;
         evict_valid <= 1'b0;
         evict_grp   <= 1'b0;
         evict_addr  <= '0;
      end else begin
         rsp_valid   <= srv_vld;
         rsp_port    <= srv_port;
         rsp_hit     <= any_hit;
         rsp_grp     <= any_hit ? hgrp : srv_port;
         rsp_state   <= any_hit ? hst : ST_NONE;
         rsp_fwd     <= srv_vld && any_hit && (hgrp != srv_port);
         rsp_stall   <= srv_stall;
         evict_valid <= do_evict;
         evict_grp   <= srv_port;
         evict_addr  <= {g_vtag[srv_port], set_idx, {OFF_W{1'b0}}};
      end
   end
endmodule

// File: rtl/sf_dir_chk.sv
`timescale 1ns/1ps
module sf_dir_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       p0_req,
   input logic       p1_req,
   input logic       arb_pend,
   input logic       rsp_valid,
   input logic       rsp_port,
   input logic       rsp_hit,
   input logic       rsp_grp,
   input logic       rsp_fwd,
   input logic [1:0] rsp_stall,
   input logic       evict_valid
);
   a_r7_p0_first: assert property (@(posedge clk) disable iff (!rst_n)
      (p0_req && !arb_pend) |=> (rsp_valid && !rsp_port && rsp_stall == 2'd1));

   a_r8_loser_next: assert property (@(posedge clk) disable iff (!rst_n)
      (p0_req && p1_req && !arb_pend) |=> ##1 (rsp_valid && rsp_port && rsp_stall == 2'd2));

   a_r8_held_first: assert property (@(posedge clk) disable iff (!rst_n)
      (p0_req && arb_pend) |=> ##1 (rsp_valid && !rsp_port && rsp_stall == 2'd2));

   a_r8_stall_range: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_stall == 2'd1 || rsp_stall == 2'd2));

   a_r3_fwd_remote: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fwd) |-> (rsp_hit && rsp_grp != rsp_port));

   a_r6_evict_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
      evict_valid |-> (rsp_valid && !rsp_hit && rsp_grp == rsp_port));
endmodule

bind snoop_filter_dir sf_dir_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .p0_req      (p0_req),
   .p1_req      (p1_req),
   .arb_pend    (arb_pend),
   .rsp_valid   (rsp_valid),
   .rsp_port    (rsp_port),
   .rsp_hit     (rsp_hit),
   .rsp_grp     (rsp_grp),
   .rsp_fwd     (rsp_fwd),
   .rsp_stall   (rsp_stall),
   .evict_valid (evict_valid)
);

// File: tb/test_snoop_filter_dir.sv
`timescale 1ns/1ps
module test_snoop_filter_dir;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        p0_req, p1_req;
   logic [1:0]  p0_op, p1_op, p0_state, p1_state;
   logic [31:0] p0_addr, p1_addr;
   logic        rsp_valid, rsp_port, rsp_hit, rsp_grp, rsp_fwd;
   logic [1:0]  rsp_state, rsp_stall;
   logic        evict_valid, evict_grp;
   logic [31:0] evict_addr;

   always #4 clk = ~clk;

   snoop_filter_dir i_snoop_filter_dir (
      .clk(clk), .rst_n(rst_n),
      .p0_req(p0_req), .p0_op(p0_op), .p0_addr(p0_addr), .p0_state(p0_state),
      .p1_req(p1_req), .p1_op(p1_op), .p1_addr(p1_addr), .p1_state(p1_state),
      .rsp_valid(rsp_valid), .rsp_port(rsp_port), .rsp_hit(rsp_hit),
      .rsp_grp(rsp_grp), .rsp_state(rsp_state), .rsp_fwd(rsp_fwd),
      .rsp_stall(rsp_stall), .evict_valid(evict_valid),
      .evict_grp(evict_grp), .evict_addr(evict_addr)
   );

   typedef struct packed {
      logic        port, hit, grp;
      logic [1:0]  st;
      logic        fwd;
      logic [1:0]  stall;
      logic        ev, ev_grp;
      logic [31:0] ev_addr;
   } exp_t;

   exp_t  q[$];
   string qn[$];
   int    total = 0;
   int    bad   = 0;

   localparam logic [1:0] LK = 2'd0, AD = 2'd1, IV = 2'd2, L3 = 2'd3;

   function automatic logic [31:0] la(int t, int s, int off);
      return {23'(t), 3'(s), 6'(off)};
   endfunction

   task automatic expect_rsp(string nm, logic port, logic hit, logic grp, logic [1:0] st,
                             logic fwd, logic [1:0] stall, logic ev, logic [31:0] eva);
      exp_t e;
      e = '{port: port, hit: hit, grp: grp, st: st, fwd: fwd, stall: stall,
            ev: ev, ev_grp: ev ? port : 1'b0, ev_addr: ev ? eva : 32'h0};
      q.push_back(e);
      qn.push_back(nm);
   endtask

   task automatic set_port(logic port, logic [1:0] op, logic [31:0] a, logic [1:0] st);
      if (!port) begin p0_req = 1; p0_op = op; p0_addr = a; p0_state = st; end
      else       begin p1_req = 1; p1_op = op; p1_addr = a; p1_state = st; end
   endtask

   task automatic send(string nm, logic port, logic [1:0] op, logic [31:0] a, logic [1:0] st,
                       logic hit, logic grp, logic [1:0] est, logic fwd,
                       logic ev, logic [31:0] eva);
      expect_rsp(nm, port, hit, grp, est, fwd, 2'd1, ev, eva);
      set_port(port, op, a, st);
      @(negedge clk);
      p0_req = 0; p1_req = 0;
   endtask

   // monitor: responses are registered, so sample away from the rising edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (rsp_valid) begin
            exp_t  g, e;
            string n;
            g = '{port: rsp_port, hit: rsp_hit, grp: rsp_grp, st: rsp_state, fwd: rsp_fwd,
                  stall: rsp_stall, ev: evict_valid,
                  ev_grp: evict_valid ? evict_grp : 1'b0,
                  ev_addr: evict_valid ? evict_addr : 32'h0};
            total++;
            if (q.size() == 0) begin
               bad++;
               $display("FAIL R8 unexpected response: actual=%h expected=none", g);
            end else begin
               e = q.pop_front();
               n = qn.pop_front();
               if (g !== e) begin
                  bad++;
                  $display("FAIL %s: actual port=%0d hit=%0d grp=%0d st=%0d fwd=%0d stall=%0d ev=%0d evgrp=%0d evaddr=%h expected port=%0d hit=%0d grp=%0d st=%0d fwd=%0d stall=%0d ev=%0d evgrp=%0d evaddr=%h",
                           n, g.port, g.hit, g.grp, g.st, g.fwd, g.stall, g.ev, g.ev_grp, g.ev_addr,
                           e.port, e.hit, e.grp, e.st, e.fwd, e.stall, e.ev, e.ev_grp, e.ev_addr);
               end
            end
         end else if (evict_valid) begin
            total++; bad++;
            $display("FAIL R6 eviction without response: actual evict_valid=1 expected 0");
         end
      end
   end

   initial begin
      repeat (20000) @(negedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 0; p0_req = 0; p1_req = 0;
      p0_op = 0; p1_op = 0; p0_state = 0; p1_state = 0; p0_addr = 0; p1_addr = 0;
      repeat (3) @(negedge clk);
      total++;
      if (rsp_valid !== 1'b0 || evict_valid !== 1'b0) begin
         bad++;
         $display("FAIL R11 reset outputs: actual rsp=%b ev=%b expected 0 0", rsp_valid, evict_valid);
      end
      rst_n = 1;
      @(negedge clk);

      // R11 R4: empty after reset, miss allocates in requester group
      send("R4 R11 first miss", 0, LK, la(5,2,0), 2'd1, 0, 0, 2'd0, 0, 0, 0);
      send("R1 R2 offset ignored", 0, LK, la(5,2,6'h2A), 2'd1, 1, 0, 2'd1, 0, 0, 0);
      send("R1 other set misses", 0, LK, la(5,3,0), 2'd2, 0, 0, 2'd0, 0, 0, 0);
      send("R4 p1 add miss", 1, AD, la(9,2,0), 2'd3, 0, 1, 2'd0, 0, 0, 0);
      send("R3 remote hit fwd", 0, LK, la(9,2,0), 2'd0, 1, 1, 2'd3, 1, 0, 0);
      send("R3 own hit no fwd", 1, LK, la(9,2,0), 2'd0, 1, 1, 2'd3, 0, 0, 0);
      send("R9 add hit old st", 0, AD, la(5,2,0), 2'd2, 1, 0, 2'd1, 0, 0, 0);
      send("R9 new st seen", 1, LK, la(5,2,0), 2'd0, 1, 0, 2'd2, 1, 0, 0);
      send("R10 inval hit", 1, IV, la(9,2,0), 2'd0, 1, 1, 2'd3, 0, 0, 0);
      send("R10 gone", 0, IV, la(9,2,0), 2'd0, 0, 0, 2'd0, 0, 0, 0);
      send("R10 no alloc", 0, IV, la(9,2,0), 2'd0, 0, 0, 2'd0, 0, 0, 0);
      repeat (2) @(negedge clk);

      // R7 R8: collision, p0 first, p1 sees p0's allocation
      expect_rsp("R7 winner", 0, 0, 0, 2'd0, 0, 2'd1, 0, 0);
      expect_rsp("R8 loser", 1, 1, 0, 2'd1, 1, 2'd2, 0, 0);
      set_port(0, LK, la(20,5,0), 2'd1);
      set_port(1, LK, la(20,5,0), 2'd3);
      @(negedge clk);
      p0_req = 0; p1_req = 0;
      repeat (3) @(negedge clk);

      // R8: held request served before a new p0 request
      expect_rsp("R7 winner D", 0, 0, 0, 2'd0, 0, 2'd1, 0, 0);
      expect_rsp("R8 held E", 1, 0, 1, 2'd0, 0, 2'd2, 0, 0);
      expect_rsp("R8 new F waits", 0, 0, 0, 2'd0, 0, 2'd2, 0, 0);
      set_port(0, LK, la(30,6,0), 2'd1);
      set_port(1, LK, la(31,6,0), 2'd1);
      @(negedge clk);
      p1_req = 0;
      set_port(0, LK, la(32,6,0), 2'd1);
      @(negedge clk);
      p0_req = 0;
      repeat (3) @(negedge clk);

      // R5: 16 fills into invalid ways, no eviction
      for (int i = 0; i < 16; i++)
         send("R5 fill", 0, AD, la(100+i,1,0), 2'd1, 0, 0, 2'd0, 0, 0, 0);
      // touch way 0; tree then points at way 8 (tag 108)
      send("R6 touch way0", 0, LK, la(100,1,0), 2'd0, 1, 0, 2'd1, 0, 0, 0);
      send("R5 other group free", 1, AD, la(200,1,0), 2'd3, 0, 1, 2'd0, 0, 0, 0);
      send("R6 evict plru", 0, AD, la(116,1,0), 2'd2, 0, 0, 2'd0, 0, 1, la(108,1,0));
      send("R6 victim gone", 0, IV, la(108,1,0), 2'd0, 0, 0, 2'd0, 0, 0, 0);
      send("R6 keeper stays", 0, IV, la(100,1,0), 2'd0, 1, 0, 2'd1, 0, 0, 0);
      send("R5 refill hole", 0, AD, la(117,1,0), 2'd1, 0, 0, 2'd0, 0, 0, 0);
      send("R2 op3 lookup", 1, L3, la(116,1,0), 2'd0, 1, 0, 2'd2, 1, 0, 0);

      repeat (4) @(negedge clk);
      total++;
      if (q.size() != 0) begin
         bad++;
         $display("FAIL R8 missing responses: actual pending=%0d expected 0", q.size());
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule